// File: doc/BRIEF.md
# Clocked Controller for an Asynchronous Static RAM

This block lets logic running on a single clock read and write an asynchronous static RAM. The memory has two chip enables (one active-low, one active-high), an active-low write strobe, an active-low output enable and two active-low byte-lane strobes. The requester raises `req` with the operation, address, write data and lane enables, and holds them until `ack` pulses. For a read, the captured word is available on `rdata` in the same cycle as `ack`, and it stays there until the next read completes.

Every dwell time of the memory is a parameter given in picoseconds, and so is the clock period. The controller rounds each dwell up to whole clock cycles. A read holds address, enables and output enable for the longest of the cycle, address, output-enable and byte-lane access times. A write holds the write strobe low for the longest of the write cycle, enable-to-end, address-to-end, pulse width, lane-to-end and data setup minimums. The address only ever changes while the write strobe is high. The controller turns the shared data bus around: it drives data only after output enable has been high for the memory's float time. Requests are taken only while the controller is idle, and never in the cycle that carries `ack`.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is asserted and after it is released with no request, `ack` is 0, both chip enables are inactive (`mem_cs1_n`=1, `mem_cs2`=0), `mem_we_n`, `mem_oe_n`, `mem_lb_n` and `mem_ub_n` are 1, `mem_doe` is 0 and `rdata` is 0.
- R2: A read returns the stored word with lane enable bit 0 selecting bits 7:0 and bit 1 selecting bits 15:8. A disabled lane reads as zero. `rdata` keeps the last read value across writes.
- R3: A write changes only the lanes whose enable bit is 1. With lane enables 00 the stored word is unchanged.
- R4: A read samples the data bus no earlier than 70 ns after address and chip enable settle and 35 ns after output enable falls. `ack` is high for exactly one cycle. From an idle start the read latency is ceil(70 ns / T)+1 cycles, and when the read is issued in the previous access's `ack` cycle it is one cycle more.
- R5: The write strobe stays low for ceil(70 ns / T) cycles. Chip enable and address have been valid at least 70 ns, and driven data at least 30 ns, when the strobe rises. Data stays driven and stable while the strobe is low. Write latency is ceil(70 ns / T)+2 from idle and +3 after a write.
- R6: `mem_addr` changes only while `mem_we_n` is high and was high in the previous cycle.
- R7: `mem_doe` is never 1 while `mem_oe_n` is 0, and rises only after `mem_oe_n` has been high for at least 30 ns. A write issued right after a read therefore takes ceil(30 ns / T)+ceil(70 ns / T)+1 cycles.
- R8: A request is accepted only while idle and not in an `ack` cycle. Each access produces exactly one `ack`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request, held until `ack` |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Write data |
| req_be | input | 2 | Lane enables: bit 0 low byte, bit 1 high byte |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | DW | Last read word, disabled lanes zero |
| mem_addr | output | AW | Memory address |
| mem_dout | output | DW | Data toward memory |
| mem_doe | output | 1 | Drive enable for `mem_dout` |
| mem_din | input | DW | Data from memory |
| mem_cs1_n | output | 1 | Chip enable, active low |
| mem_cs2 | output | 1 | Chip enable, active high |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_lb_n | output | 1 | Low lane strobe, active low |
| mem_ub_n | output | 1 | High lane strobe, active low |

## Verification
A dwell counter that stops one count early shows up on the access that uses it. `ack` arrives a cycle early, and the memory-side monitor measures a strobe or access window below the minimum on that same access. A stale turnaround count shows up only on a write that directly follows a read: `mem_doe` rises too soon after `mem_oe_n` rises, within the first few cycles of that write. A wrong lane latch shows up in the next read-back of the affected word, as a lane that is nonzero where zero was due or a lane that was overwritten.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_RD     = 3'd1,
    ST_WTURN  = 3'd2,
    ST_WPULSE = 3'd3,
    ST_WHOLD  = 3'd4
  } sc_state_e;

  // active-high internal view of the memory controls
  typedef struct packed {
    logic sel;
    logic oe;
    logic we;
    logic drv;
  } sc_ctl_t;

  function automatic int unsigned cyc_of(int unsigned t_ps, int unsigned clk_ps);
    int unsigned c;
    c = (t_ps + clk_ps - 1) / clk_ps;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctrl_rst_sync.sv
`timescale 1ns/1ps
module sram_ctrl_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/sram_ctrl_fsm.sv
`timescale 1ns/1ps
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned N_RD = 18,
  parameter int unsigned N_WR = 18
)(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    req,
  input  logic    req_wr,
  input  logic    turn_ok,
  output logic    start,
  output logic    rd_cap,
  output logic    ack,
  output sc_ctl_t ctl
);

  localparam int unsigned N_MAX = max2(N_RD, N_WR);
  localparam int unsigned CNT_W = (N_MAX > 1) ? $clog2(N_MAX) : 1;
  localparam logic [CNT_W-1:0] RD_LAST = CNT_W'(N_RD - 1);
  localparam logic [CNT_W-1:0] WR_LAST = CNT_W'(N_WR - 1);

  sc_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             wr_done;
  logic             ack_q;
  sc_ctl_t          ctl_q, ctl_d;

  // next state and dwell counter
  always_comb begin
    state_d = state_q;
    cnt_d   = '0;
    cnt_en  = 1'b0;
    start   = 1'b0;
    rd_cap  = 1'b0;
    wr_done = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req && !ack_q) begin
          start   = 1'b1;
          state_d = req_wr ? ST_WTURN : ST_RD;
        end
      end
      ST_RD: begin
        cnt_en = 1'b1;
        if (cnt_q == RD_LAST) begin
          rd_cap  = 1'b1;
          state_d = ST_IDLE;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_WTURN: begin
        if (turn_ok) state_d = ST_WPULSE;
      end
      ST_WPULSE: begin
        cnt_en = 1'b1;
        if (cnt_q == WR_LAST) begin
          wr_done = 1'b1;
          state_d = ST_WHOLD;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_WHOLD: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  // controls are registered from the next state so they switch cleanly
  always_comb begin
    ctl_d.sel = (state_d != ST_IDLE);
    ctl_d.oe  = (state_d == ST_RD);
    ctl_d.we  = (state_d == ST_WPULSE);
    ctl_d.drv = (state_d == ST_WPULSE) || (state_d == ST_WHOLD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      ctl_q   <= '0;
      ack_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (cnt_en || (state_q != state_d)) cnt_q <= cnt_d;
      ctl_q   <= ctl_d;
      ack_q   <= rd_cap | wr_done;
    end
  end

  assign ack = ack_q;
  assign ctl = ctl_q;

endmodule

// File: rtl/sram_ctrl_turn.sv
`timescale 1ns/1ps
module sram_ctrl_turn #(
  parameter int unsigned N_TURN = 8
)(
  input  logic clk,
  input  logic rst_n,
  input  logic oe_on,
  output logic turn_ok
);

  localparam int unsigned HW = $clog2(N_TURN + 1);
  localparam logic [HW-1:0] HZ_FULL = HW'(N_TURN);

  logic [HW-1:0] hz_q, hz_d;
  logic          hz_en;

  assign turn_ok = (hz_q == HZ_FULL);

  always_comb begin
    hz_en = oe_on | ~turn_ok;
    hz_d  = oe_on ? '0 : hz_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     hz_q <= HZ_FULL;
    else if (hz_en) hz_q <= hz_d;
  end

endmodule

// File: rtl/sram_ctrl_dpath.sv
`timescale 1ns/1ps
module sram_ctrl_dpath #(
  parameter int unsigned AW = 17,
  parameter int unsigned DW = 16
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          rd_cap,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [1:0]    req_be,
  input  logic [DW-1:0] mem_din,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] wdata_q,
  output logic [1:0]    be_q,
  output logic [DW-1:0] rdata
);

  localparam int unsigned LANE_W = DW / 2;

  logic [DW-1:0] rdata_q, rdata_d;

  for (genvar g = 0; g < 2; g++) begin : g_lane
    assign rdata_d[g*LANE_W +: LANE_W] = be_q[g] ? mem_din[g*LANE_W +: LANE_W] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
    end else if (start) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      be_q    <= req_be;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (rd_cap) rdata_q <= rdata_d;
  end

  assign rdata = rdata_q;

endmodule

// File: rtl/sram_async_ctrl.sv
`timescale 1ns/1ps
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned AW        = 17,
  parameter int unsigned DW        = 16,
  parameter int unsigned CLK_PS    = 4000,
  parameter int unsigned T_RC_PS   = 70000,
  parameter int unsigned T_AA_PS   = 70000,
  parameter int unsigned T_OE_PS   = 35000,
  parameter int unsigned T_BA_PS   = 70000,
  parameter int unsigned T_WC_PS   = 70000,
  parameter int unsigned T_CW_PS   = 70000,
  parameter int unsigned T_AW_PS   = 70000,
  parameter int unsigned T_WP_PS   = 35000,
  parameter int unsigned T_BW_PS   = 30000,
  parameter int unsigned T_DW_PS   = 30000,
  parameter int unsigned T_OHZ_PS  = 30000
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          req_wr,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [1:0]    req_be,
  output logic          ack,
  output logic [DW-1:0] rdata,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_dout,
  output logic          mem_doe,
  input  logic [DW-1:0] mem_din,
  output logic          mem_cs1_n,
  output logic          mem_cs2,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  output logic          mem_lb_n,
  output logic          mem_ub_n
);

  localparam int unsigned N_RD = max2(max2(cyc_of(T_RC_PS, CLK_PS), cyc_of(T_AA_PS, CLK_PS)),
                                      max2(cyc_of(T_OE_PS, CLK_PS), cyc_of(T_BA_PS, CLK_PS)));
  localparam int unsigned N_WR = max2(max2(max2(cyc_of(T_WC_PS, CLK_PS), cyc_of(T_CW_PS, CLK_PS)),
                                           max2(cyc_of(T_AW_PS, CLK_PS), cyc_of(T_WP_PS, CLK_PS))),
                                      max2(cyc_of(T_BW_PS, CLK_PS), cyc_of(T_DW_PS, CLK_PS)));
  localparam int unsigned N_TURN = cyc_of(T_OHZ_PS, CLK_PS);

  logic    rst_sync_n;
  logic    start, rd_cap, turn_ok;
  sc_ctl_t ctl;
  logic [1:0] be_q;

  sram_ctrl_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  sram_ctrl_fsm #(.N_RD(N_RD), .N_WR(N_WR)) u_fsm (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .req     (req),
    .req_wr  (req_wr),
    .turn_ok (turn_ok),
    .start   (start),
    .rd_cap  (rd_cap),
    .ack     (ack),
    .ctl     (ctl)
  );

  sram_ctrl_turn #(.N_TURN(N_TURN)) u_turn (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .oe_on   (ctl.oe),
    .turn_ok (turn_ok)
  );

  sram_ctrl_dpath #(.AW(AW), .DW(DW)) u_dpath (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .start     (start),
    .rd_cap    (rd_cap),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_be    (req_be),
    .mem_din   (mem_din),
    .addr_q    (mem_addr),
    .wdata_q   (mem_dout),
    .be_q      (be_q),
    .rdata     (rdata)
  );

  assign mem_cs1_n = ~ctl.sel;
  assign mem_cs2   =  ctl.sel;
  assign mem_oe_n  = ~ctl.oe;
  assign mem_we_n  = ~ctl.we;
  assign mem_doe   =  ctl.drv;
  assign mem_lb_n  = ~(ctl.sel & be_q[0]);
  assign mem_ub_n  = ~(ctl.sel & be_q[1]);

endmodule

// File: rtl/sram_async_ctrl_chk.sv
`timescale 1ns/1ps
module sram_async_ctrl_chk #(
  parameter int unsigned AW     = 17,
  parameter int unsigned DW     = 16,
  parameter int unsigned N_WR   = 18,
  parameter int unsigned N_TURN = 8
)(
  input logic          clk,
  input logic          rst_n,
  input logic          ack,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_dout,
  input logic          mem_doe,
  input logic          mem_we_n,
  input logic          mem_oe_n
);

  localparam int unsigned WL_W = $clog2(N_WR + 1);
  localparam int unsigned OH_W = $clog2(N_TURN + 1);

  logic [WL_W-1:0] wl_q;
  logic [OH_W-1:0] oh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wl_q <= '0;
      oh_q <= OH_W'(N_TURN);
    end else begin
      if (mem_we_n)                   wl_q <= '0;
      else if (wl_q != WL_W'(N_WR))   wl_q <= wl_q + 1'b1;
      if (!mem_oe_n)                  oh_q <= '0;
      else if (oh_q != OH_W'(N_TURN)) oh_q <= oh_q + 1'b1;
    end
  end

  // R4
  ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  // R5
  we_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (wl_q == WL_W'(N_WR)));

  // R5
  wdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (mem_doe && $stable(mem_dout)));

  // R6
  addr_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mem_addr) |-> (mem_we_n && $past(mem_we_n)));

  // R7
  doe_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_doe |-> mem_oe_n);

  // R7
  turn_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_doe) |-> (oh_q >= OH_W'(N_TURN)));

endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(
  .AW(AW), .DW(DW), .N_WR(N_WR), .N_TURN(N_TURN)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ack      (ack),
  .mem_addr (mem_addr),
  .mem_dout (mem_dout),
  .mem_doe  (mem_doe),
  .mem_we_n (mem_we_n),
  .mem_oe_n (mem_oe_n)
);

// File: tb/sram_async_ctrl_tb.sv
`timescale 1ns/1ps
module sram_async_ctrl_tb;

  localparam int AW     = 4;
  localparam int DW     = 16;
  localparam int CLK_PS = 4000;

  function automatic int cdiv(int t, int c);
    return (t + c - 1) / c;
  endfunction
  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  localparam int E_RD   = imax(cdiv(70000, CLK_PS), cdiv(35000, CLK_PS));
  localparam int E_WR   = imax(cdiv(70000, CLK_PS), cdiv(35000, CLK_PS));
  localparam int E_TURN = cdiv(30000, CLK_PS);

  logic          clk, rst_n;
  logic          req, req_wr;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic [1:0]    req_be;
  logic          ack;
  logic [DW-1:0] rdata;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_dout, mem_din;
  logic          mem_doe, mem_cs1_n, mem_cs2, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n;

  sram_async_ctrl #(.AW(AW), .DW(DW), .CLK_PS(CLK_PS)) u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_be(req_be), .ack(ack), .rdata(rdata),
    .mem_addr(mem_addr), .mem_dout(mem_dout), .mem_doe(mem_doe), .mem_din(mem_din),
    .mem_cs1_n(mem_cs1_n), .mem_cs2(mem_cs2), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int acks_seen = 0;
  int accesses = 0;
  bit done = 1'b0;
  bit ack_prev = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // memory model
  logic [DW-1:0] ram  [16];
  logic [DW-1:0] shad [16];
  wire sel = !mem_cs1_n && mem_cs2;

  assign mem_din = (sel && !mem_oe_n && mem_we_n) ?
                   {mem_ub_n ? 8'h5A : ram[mem_addr][15:8], mem_lb_n ? 8'hC3 : ram[mem_addr][7:0]} :
                   16'h9696;

  realtime t_addr = 0, t_sel = 0, t_oe_fall = 0, t_oe_rise = 0, t_we_fall = 0, t_drv = 0;

  always @(mem_addr) begin
    t_addr = $realtime;
    if (rst_n) chk(mem_we_n === 1'b1, "R6 addr change with strobe low", 32'(mem_we_n), 1);
  end
  always @(negedge mem_cs1_n) t_sel = $realtime;
  always @(negedge mem_oe_n)  t_oe_fall = $realtime;
  always @(posedge mem_oe_n)  t_oe_rise = $realtime;
  always @(negedge mem_we_n)  t_we_fall = $realtime;

  always @(posedge mem_doe) begin
    if (rst_n) begin
      chk(mem_oe_n === 1'b1, "R7 drive while output enabled", 32'(mem_oe_n), 1);
      chk(($realtime - t_oe_rise) >= 30.0, "R7 float gap ns", 32'(int'($realtime - t_oe_rise)), 30);
    end
    t_drv = $realtime;
  end

  always @(posedge mem_we_n) begin
    if (rst_n && sel) begin
      chk(($realtime - t_we_fall) >= 35.0, "R5 strobe width ns", 32'(int'($realtime - t_we_fall)), 35);
      chk(($realtime - t_sel) >= 70.0, "R5 enable to end ns", 32'(int'($realtime - t_sel)), 70);
      chk(($realtime - t_addr) >= 70.0, "R5 address to end ns", 32'(int'($realtime - t_addr)), 70);
      chk(($realtime - t_drv) >= 30.0, "R5 data setup ns", 32'(int'($realtime - t_drv)), 30);
      chk(mem_doe === 1'b1, "R5 data driven at end", 32'(mem_doe), 1);
      if (!mem_lb_n) ram[mem_addr][7:0]  = mem_dout[7:0];
      if (!mem_ub_n) ram[mem_addr][15:8] = mem_dout[15:8];
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (ack) acks_seen++;
      if (ack && ack_prev) chk(1'b0, "R4 ack longer than one cycle", 1, 0);
      ack_prev = ack;
    end
  end

  // 0 = idle start, 1 = after read, 2 = after write
  int prev = 0;
  logic [DW-1:0] last_rd = '0;

  function automatic int exp_lat(bit wr, int pv);
    if (pv == 0)  return wr ? E_WR + 2 : E_RD + 1;
    if (!wr)      return E_RD + 2;
    if (pv == 2)  return E_WR + 3;
    return imax(E_WR + 3, E_TURN + E_WR + 1);
  endfunction

  function automatic logic [DW-1:0] lane_mask(logic [1:0] be);
    return {{8{be[1]}}, {8{be[0]}}};
  endfunction

  task automatic run(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [1:0] be);
    int lat;
    int el;
    realtime cap;
    logic [DW-1:0] m;
    req = 1'b1; req_wr = wr; req_addr = a; req_wdata = d; req_be = be;
    el  = exp_lat(wr, prev);
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!ack && lat < 400);
    req = 1'b0;
    accesses++;
    if (!ack) begin
      chk(1'b0, "R8 no ack (watchdog)", 0, 1);
      return;
    end
    m = lane_mask(be);
    if (wr) begin
      chk(lat == el, (prev == 1) ? "R7 write-after-read latency" : "R5 write latency", 32'(lat), 32'(el));
      chk(rdata === last_rd, "R2 rdata held across write", 32'(rdata), 32'(last_rd));
      shad[a] = (shad[a] & ~m) | (d & m);
      prev = 2;
    end else begin
      cap = $realtime - 2.0;
      chk(lat == el, "R4 read latency", 32'(lat), 32'(el));
      chk((cap - t_addr) >= 70.0 && (cap - t_sel) >= 70.0, "R4 address/enable to capture ns",
          32'(int'(cap - t_sel)), 70);
      chk((cap - t_oe_fall) >= 35.0, "R4 output enable to capture ns", 32'(int'(cap - t_oe_fall)), 35);
      chk(rdata === (shad[a] & m), "R2 read data", 32'(rdata), 32'(shad[a] & m));
      last_rd = rdata;
      prev = 1;
    end
  endtask

  function automatic logic [DW-1:0] pat(int a);
    return 16'(a * 16'h1357) ^ 16'hA0C5;
  endfunction

  initial begin
    req = 1'b0; req_wr = 1'b0; req_addr = '0; req_wdata = '0; req_be = '0;
    rst_n = 1'b0;
    for (int i = 0; i < 16; i++) begin ram[i] = '0; shad[i] = '0; end
    repeat (4) @(negedge clk);
    chk({ack, mem_cs1_n, mem_cs2, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_doe} === 8'b0_1_0_1_1_1_1_0,
        "R1 controls in reset", 32'({ack, mem_cs1_n, mem_cs2, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_doe}), 32'h5E);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk({ack, mem_cs1_n, mem_cs2, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_doe} === 8'b0_1_0_1_1_1_1_0,
        "R1 controls after release", 32'({ack, mem_cs1_n, mem_cs2, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_doe}), 32'h5E);
    chk(rdata === '0, "R1 rdata after release", 32'(rdata), 0);

    // full-word fill, back-to-back writes
    for (int a = 0; a < 16; a++) run(1'b1, AW'(a), pat(a), 2'b11);

    // every lane combination on every word (R2), including 00
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 4; b++) run(1'b0, AW'(a), '0, 2'(b));

    // partial writes with every lane combination, then full read-back (R3)
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 4; b++) begin
        run(1'b1, AW'(a), ~pat(a) ^ 16'(b * 16'h0F11), 2'(b));
        run(1'b0, AW'(a), '0, 2'b11);
        chk(rdata === shad[a], "R3 lanes after partial write", 32'(rdata), 32'(shad[a]));
      end

    // idle gap, then fresh read and fresh write latencies
    repeat (30) @(negedge clk);
    prev = 0;
    run(1'b0, AW'(5), '0, 2'b11);
    repeat (30) @(negedge clk);
    prev = 0;
    run(1'b1, AW'(9), 16'h1234, 2'b11);
    run(1'b0, AW'(9), '0, 2'b11);

    repeat (5) @(negedge clk);
    chk(acks_seen == accesses, "R8 one ack per access", 32'(acks_seen), 32'(accesses));
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R8 watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule